// File: doc/BRIEF.md
# Write-once system option register

This block holds three chip-wide option bits: watchdog enable, watchdog long-timeout select and stop-mode enable. Each bit has a fixed value after reset. Software gets exactly one write to change the bits. The first bus write after reset commits all three bits at once and sets an internal lock. Every write after that is dropped until the next reset. The option bits go straight to the watchdog and power logic, and they can also be read back over the bus.

The block also guards stop entry. A stop request from the core is acted on at its rising edge. If stop mode is enabled, the block gives a one-cycle stop-entry strobe. If stop mode is disabled, it gives a one-cycle illegal-opcode reset request instead.

Top module: `sysopt_reg`

## Requirements
- R1: After reset, `wdog_en_o`=1, `wdog_long_o`=1 and `stop_en_o`=0, so `rd_data_o` reads 8'hC0.
- R2: The first cycle with `wr_en_i`=1 after reset loads `wr_data_i` bit 7 into watchdog enable, bit 6 into timeout select and bit 5 into stop enable. The new values appear on the outputs in the next cycle.
- R3: Any later write is ignored, and the option bits do not change until reset is asserted again.
- R4: `rd_data_o` bit 7 is watchdog enable, bit 6 is timeout select and bit 5 is stop enable. Bits 4 to 0 read 0.
- R5: On a rising edge of `stop_req_i` while `stop_en_o`=1, `stop_enter_o` is high for exactly one cycle, in the cycle after the edge, and `illop_rst_o` stays low.
- R6: On a rising edge of `stop_req_i` while `stop_en_o`=0, `illop_rst_o` is high for exactly one cycle, in the cycle after the edge, and `stop_enter_o` stays low.
- R7: Holding `stop_req_i` high gives no further pulses, and `stop_enter_o` and `illop_rst_o` are never high together.
- R8: Reset clears the lock and restores the reset values, so the first write after a new reset takes effect again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read-back data |
| stop_req_i | input | 1 | Stop instruction request, level |
| wdog_en_o | output | 1 | Watchdog enabled |
| wdog_long_o | output | 1 | Long watchdog timeout selected |
| stop_en_o | output | 1 | Stop mode enabled |
| stop_enter_o | output | 1 | One-cycle stop-entry strobe |
| illop_rst_o | output | 1 | One-cycle illegal-opcode reset request |

## Verification
The checker assumes that `wr_en_i`, `wr_data_i` and `stop_req_i` are synchronous to `clk_i` and stable across each rising edge. It also assumes that a stop request is a level which only counts again after it has dropped. The bench drives every input on the falling edge. Its random stop requests are held for one to four cycles and always fall before a new request starts. Reset is applied in several epochs, so that the write-once lock is set up again in each one.

// File: rtl/sysopt_pkg.sv
package sysopt_pkg;
  localparam int NUM_OPT = 3;
  localparam int TOP_BIT = 7;
  // index 0: watchdog enable, 1: long timeout, 2: stop enable
  localparam logic [NUM_OPT-1:0] OPT_RST = 3'b011;

  function automatic int opt_pos(input int idx);
    return TOP_BIT - idx;
  endfunction
endpackage

// File: rtl/sysopt_lock_reg.sv
module sysopt_lock_reg
  import sysopt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  output logic [NUM_OPT-1:0]  opt_o,
  output logic                lock_o
);
  logic lock_q;
  logic load;

  assign load = wr_en_i & ~lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lock_q <= 1'b0;
    else if (wr_en_i) lock_q <= 1'b1;
  end

  for (genvar i = 0; i < NUM_OPT; i++) begin : g_opt
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bit_q <= OPT_RST[i];
      else if (load) bit_q <= wr_data_i[opt_pos(i)];
    end
    assign opt_o[i] = bit_q;
  end

  assign lock_o = lock_q;
endmodule

// File: rtl/sysopt_rd_mux.sv
module sysopt_rd_mux
  import sysopt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [NUM_OPT-1:0] opt_i,
  output logic [DATA_W-1:0]  rd_data_o
);
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (b <= TOP_BIT && b > TOP_BIT - NUM_OPT) begin : g_impl
      assign rd_data_o[b] = opt_i[TOP_BIT - b];
    end else begin : g_rsvd
      assign rd_data_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/sysopt_stop_ctl.sv
module sysopt_stop_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_req_i,
  input  logic stop_en_i,
  output logic stop_enter_o,
  output logic illop_rst_o
);
  logic req_q, enter_q, illop_q, req_rise;

  assign req_rise = stop_req_i & ~req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      enter_q <= 1'b0;
      illop_q <= 1'b0;
    end else begin
      req_q   <= stop_req_i;
      enter_q <= req_rise & stop_en_i;
      illop_q <= req_rise & ~stop_en_i;
    end
  end

  assign stop_enter_o = enter_q;
  assign illop_rst_o  = illop_q;
endmodule

// File: rtl/sysopt_reg.sv
module sysopt_reg
  import sysopt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              stop_req_i,
  output logic              wdog_en_o,
  output logic              wdog_long_o,
  output logic              stop_en_o,
  output logic              stop_enter_o,
  output logic              illop_rst_o
);
  logic [NUM_OPT-1:0] opt;
  logic               lock;

  sysopt_lock_reg #(.DATA_W(DATA_W)) u_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .opt_o(opt), .lock_o(lock)
  );

  sysopt_rd_mux #(.DATA_W(DATA_W)) u_rd (
    .opt_i(opt), .rd_data_o(rd_data_o)
  );

  sysopt_stop_ctl u_stop (
    .clk_i(clk_i), .rst_ni(rst_ni), .stop_req_i(stop_req_i),
    .stop_en_i(opt[2]), .stop_enter_o(stop_enter_o), .illop_rst_o(illop_rst_o)
  );

  assign wdog_en_o   = opt[0];
  assign wdog_long_o = opt[1];
  assign stop_en_o   = opt[2];
endmodule

// File: rtl/sysopt_reg_chk.sv
module sysopt_reg_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              stop_req_i,
  input logic              wdog_en_o,
  input logic              wdog_long_o,
  input logic              stop_en_o,
  input logic              stop_enter_o,
  input logic              illop_rst_o,
  input logic              lock
);
  AST_WRITE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !lock) |=> ({wdog_en_o, wdog_long_o, stop_en_o} == $past(wr_data_i[7:5]))); // R2
  AST_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock |=> $stable({wdog_en_o, wdog_long_o, stop_en_o})); // R3
  AST_RD_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o == {wdog_en_o, wdog_long_o, stop_en_o, 5'b0}); // R4
  AST_STOP_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_enter_o |-> ($past(stop_en_o) && $past(stop_req_i))); // R5
  AST_ILLOP_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illop_rst_o |-> (!$past(stop_en_o) && $past(stop_req_i))); // R6
  AST_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({stop_enter_o, illop_rst_o})); // R7
  AST_ILLOP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illop_rst_o |=> !illop_rst_o); // R7
  AST_STOP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_enter_o |=> !stop_enter_o); // R7
endmodule

bind sysopt_reg sysopt_reg_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sysopt_reg_tb.sv
module sysopt_reg_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic stop_req = 1'b0;
  logic [7:0] rd_data;
  logic wdog_en, wdog_long, stop_en, stop_enter, illop_rst;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  logic [2:0] m_opt;  // {wdog_en, long, stop_en}
  bit m_lock;

  always #5 clk = ~clk;

  sysopt_reg dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .stop_req_i(stop_req), .wdog_en_o(wdog_en),
    .wdog_long_o(wdog_long), .stop_en_o(stop_en), .stop_enter_o(stop_enter),
    .illop_rst_o(illop_rst)
  );

  function automatic logic [7:0] exp_rd(input logic [2:0] o);
    return {o, 5'b0};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_opts(input string req);
    check(req, {wdog_en, wdog_long, stop_en}, m_opt);
    check({req, "/R4"}, rd_data, exp_rd(m_opt));
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; wr_en = 1'b0; stop_req = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    m_opt = 3'b110; m_lock = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] d, input string req);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
    if (!m_lock) begin m_opt = d[7:5]; m_lock = 1'b1; end
    check_opts(req);
  endtask

  // request held for len cycles, then dropped one cycle
  task automatic do_stop(input int len);
    bit en;
    en = m_opt[0];
    stop_req = 1'b1;
    @(negedge clk);
    check(en ? "R5" : "R6", {stop_enter, illop_rst}, en ? 2'b10 : 2'b01);
    for (int k = 1; k < len; k++) begin
      @(negedge clk);
      check("R7", {stop_enter, illop_rst}, 0);
    end
    stop_req = 1'b0;
    @(negedge clk);
    check("R7", {stop_enter, illop_rst}, 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    do_reset();
    check_opts("R1");
    check("R1", rd_data, 8'hC0);
    do_stop(1);                 // R6: stop disabled at reset
    do_write(8'h3F, "R2");      // wdog off, short, stop on; low bits ignored
    check("R4", rd_data, 8'h20);
    do_write(8'hC0, "R3");      // ignored
    do_write(8'hFF, "R3");
    do_stop(3);                 // R5 plus held request R7
    do_reset();
    check_opts("R8");
    do_write(8'h40, "R8");
    do_stop(2);
    for (int ep = 0; ep < 40; ep++) begin
      do_reset();
      check_opts("R1");
      for (int s = 0; s < 12; s++) begin
        case ($urandom_range(0, 2))
          0: do_write(8'($urandom), m_lock ? "R3" : "R2");
          1: do_stop($urandom_range(1, 4));
          default: begin @(negedge clk); check_opts("R3"); end
        endcase
      end
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end
endmodule